// File: doc/BRIEF.md
# Resumable Word Block Copy Engine

The engine moves a block of 32-bit words from one memory region to another. Its three operands (source byte address, destination byte address and remaining word count) arrive from the register file at the moment the copy command is issued, so the command itself needs no operand fields and fits in a single instruction word. The count has no relation to the bus width: a single command may move any number of words, one memory transaction per read and one per write, over a plain request/acknowledge port.

A long copy must not lock out interrupts. Between word moves the engine samples an interrupt request line. When that line is high, it stops, hands the source, destination and count back to the register file exactly as far as the copy has progressed, and reports the address of the copy instruction itself as the exception PC. When the handler returns, the same instruction executes again with the updated registers and carries on from the point where it stopped. A completed copy writes back its final registers and pulses `done`.

The controller has six states. IDLE waits for `start`. CHECK is the word boundary: it goes to FINISH when the count is zero, to SUSPEND when an interrupt is pending, and otherwise to READ. READ holds a read request at the source pointer until it is acknowledged, then goes to WRITE. WRITE holds a write request at the destination pointer until it is acknowledged, and then steps the registers and returns to CHECK. FINISH and SUSPEND each last one cycle, write the registers back, and return to IDLE.

Top module: `blk_copy_engine`

## Requirements
- R1: While `busy` is low, `mem_req` stays low. `busy` rises in the cycle after `start` is sampled in IDLE and stays high until the engine returns to IDLE.
- R2: Each word is moved as a read (`mem_we`=0) at the current source address followed by a write (`mem_we`=1) at the current destination address. A request holds its address and direction until it is acknowledged.
- R3: The source and destination pointers advance by 4 bytes, and the count drops by 1, only when a write is acknowledged.
- R4: A copy issued with a count of zero raises `done` without issuing any memory request.
- R5: `done` is high for exactly one cycle. In that cycle `wb_valid` is high, `wb_len` is 0, `wb_src`/`wb_dst` equal the start values plus 4 times the original count, and `intr_taken` is low.
- R6: The interrupt request is sampled only at word boundaries. Once the read of a word has been acknowledged, that word is written, with the data that was read, before the engine can stop.
- R7: When the engine stops for an interrupt, `intr_taken` and `wb_valid` are high for one cycle, `done` stays low, and `wb_len` equals the original count minus the number of words written. `wb_src` and `wb_dst` are advanced by 4 bytes for each word written.
- R8: In the cycle of `intr_taken`, `epc` equals the `pc_in` value captured at `start` (the address of the copy instruction).
- R9: Issuing the copy again with the written-back registers moves only the remaining words. Across both runs the number of word writes equals the original count, and the destination region ends up as a full copy.
- R10: When the count is zero at a word boundary, completion takes precedence over a pending interrupt: `done` is raised and `intr_taken` is not.
- R11: A `start` pulse while `busy` is high is ignored and does not alter the operands of the copy in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue the copy command (sampled only in IDLE) |
| pc_in | input | AW | Address of the copy instruction |
| src_in | input | AW | Source byte address from the register file |
| dst_in | input | AW | Destination byte address from the register file |
| len_in | input | LW | Remaining word count from the register file |
| irq_req | input | 1 | Interrupt request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Memory acknowledge, completes the current request |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle pulse: copy complete |
| intr_taken | output | 1 | One-cycle pulse: copy suspended for an interrupt |
| wb_valid | output | 1 | Register write-back strobe |
| wb_src | output | AW | Source pointer to write back |
| wb_dst | output | AW | Destination pointer to write back |
| wb_len | output | LW | Remaining count to write back |
| epc | output | AW | Exception PC to save (address of the copy instruction) |

## Verification
A wrong step in the pointer or count registers shows up at the first write-back strobe. It appears there as a `wb_len` that does not match the number of writes the bench counted, or as destination words landing at shifted addresses or holding the wrong data, so a single suspended copy exposes it within a few cycles of the interrupt. A controller that samples the interrupt inside a word move leaves a word that was read but never written. The bench catches this by comparing the final write count and the memory contents with the written-back count. A wrong choice between FINISH and SUSPEND shows as the wrong pulse (`done` against `intr_taken`) in the cycle after the last boundary. A captured PC that was lost shows as a wrong `epc` at that same pulse.

// File: rtl/bce_pkg.sv
package bce_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CHECK   = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_FINISH  = 3'd4,
        ST_SUSPEND = 3'd5
    } bce_state_e;

endpackage

// File: rtl/bce_fsm.sv
module bce_fsm
    import bce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       len_zero,
    input  logic       irq_req,
    input  logic       mem_ack,
    output bce_state_e state,
    output logic       load,
    output logic       step,
    output logic       capture,
    output logic       busy,
    output logic       done,
    output logic       intr_taken,
    output logic       wb_valid
);

    bce_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CHECK;
            ST_CHECK: begin
                if (len_zero)     state_d = ST_FINISH;
                else if (irq_req) state_d = ST_SUSPEND;
                else              state_d = ST_READ;
            end
            ST_READ:    if (mem_ack) state_d = ST_WRITE;
            ST_WRITE:   if (mem_ack) state_d = ST_CHECK;
            ST_FINISH:  state_d = ST_IDLE;
            ST_SUSPEND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load       = 1'b0;
        step       = 1'b0;
        capture    = 1'b0;
        done       = 1'b0;
        intr_taken = 1'b0;
        wb_valid   = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_CHECK:   ;
            ST_READ:    capture = mem_ack;
            ST_WRITE:   step    = mem_ack;
            ST_FINISH: begin
                done     = 1'b1;
                wb_valid = 1'b1;
            end
            ST_SUSPEND: begin
                intr_taken = 1'b1;
                wb_valid   = 1'b1;
            end
            default:    busy = 1'b0;
        endcase
    end

    assign state = state_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5

    AST_INTR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        intr_taken |=> (!intr_taken && !busy)); // R7

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !load); // R11

endmodule

// File: rtl/bce_progress.sv
module bce_progress #(
    parameter int AW = 32,
    parameter int LW = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [LW-1:0] len_in,
    input  logic [AW-1:0] pc_in,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [LW-1:0] len_q,
    output logic [AW-1:0] pc_q,
    output logic          len_zero
);

    localparam logic [AW-1:0] PTR_INC = AW'(STEP_BYTES);
    localparam logic [LW-1:0] LEN_DEC = LW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            len_q <= '0;
            pc_q  <= '0;
        end else if (load) begin
            src_q <= src_in;
            dst_q <= dst_in;
            len_q <= len_in;
            pc_q  <= pc_in;
        end else if (step) begin
            src_q <= src_q + PTR_INC;
            dst_q <= dst_q + PTR_INC;
            len_q <= len_q - LEN_DEC;
        end
    end

    assign len_zero = (len_q == '0);

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> ($stable(len_q) && $stable(src_q) && $stable(dst_q))); // R3

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(pc_q)); // R8

endmodule

// File: rtl/bce_memif.sv
module bce_memif
    import bce_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bce_state_e    state,
    input  logic          capture,
    input  logic          mem_ack,
    input  logic [AW-1:0] src_q,
    input  logic [AW-1:0] dst_q,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    logic [DW-1:0] buf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       buf_q <= '0;
        else if (capture) buf_q <= mem_rdata;
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        unique case (state)
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
            end
            default: ;
        endcase
    end

    assign mem_wdata = buf_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2

    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we && mem_wdata == $past(mem_rdata))); // R6

endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
    import bce_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [LW-1:0] len_in,
    input  logic          irq_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          busy,
    output logic          done,
    output logic          intr_taken,
    output logic          wb_valid,
    output logic [AW-1:0] wb_src,
    output logic [AW-1:0] wb_dst,
    output logic [LW-1:0] wb_len,
    output logic [AW-1:0] epc
);

    localparam int WORD_BYTES = DW / 8;

    bce_state_e    state;
    logic          load, step, capture, len_zero;
    logic [AW-1:0] src_q, dst_q, pc_q;
    logic [LW-1:0] len_q;

    bce_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len_zero   (len_zero),
        .irq_req    (irq_req),
        .mem_ack    (mem_ack),
        .state      (state),
        .load       (load),
        .step       (step),
        .capture    (capture),
        .busy       (busy),
        .done       (done),
        .intr_taken (intr_taken),
        .wb_valid   (wb_valid)
    );

    bce_progress #(.AW(AW), .LW(LW), .STEP_BYTES(WORD_BYTES)) u_progress (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .src_in   (src_in),
        .dst_in   (dst_in),
        .len_in   (len_in),
        .pc_in    (pc_in),
        .src_q    (src_q),
        .dst_q    (dst_q),
        .len_q    (len_q),
        .pc_q     (pc_q),
        .len_zero (len_zero)
    );

    bce_memif #(.AW(AW), .DW(DW)) u_memif (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .capture   (capture),
        .mem_ack   (mem_ack),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    assign wb_src = src_q;
    assign wb_dst = dst_q;
    assign wb_len = len_q;
    assign epc    = pc_q;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R1

    AST_DONE_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wb_len == '0 && !intr_taken)); // R5

endmodule

// File: tb/blk_copy_engine_tb_top.sv
`timescale 1ns/1ps
module blk_copy_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pc_in = '0, src_in = '0, dst_in = '0, len_in = '0;
    logic        irq_req = 1'b0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        busy, done, intr_taken, wb_valid;
    logic [31:0] wb_src, wb_dst, wb_len, epc;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, req_cnt = 0;
    longint cyc = 0;
    logic [31:0] mem [0:255];

    always #4 clk = ~clk;

    blk_copy_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
        .src_in(src_in), .dst_in(dst_in), .len_in(len_in), .irq_req(irq_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .intr_taken(intr_taken), .wb_valid(wb_valid),
        .wb_src(wb_src), .wb_dst(wb_dst), .wb_len(wb_len), .epc(epc)
    );

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req) req_cnt <= req_cnt + 1;
        if (mem_req && mem_ack) begin
            if (mem_we) wr_cnt <= wr_cnt + 1;
            else        rd_cnt <= rd_cnt + 1;
        end
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] pattern(int i);
        return 32'hA5000000 ^ (i * 32'h01010101) ^ 32'h3C;
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? pattern(i) : 32'hDEAD_0000 + i;
    endtask

    task automatic issue(input logic [31:0] pc, s, d, l);
        @(negedge clk);
        pc_in = pc; src_in = s; dst_in = d; len_in = l;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // waits at negedge for done or intr_taken; leaves sampling point there
    task automatic wait_end();
        while (!(done || intr_taken)) @(negedge clk);
    endtask

    task automatic test_reset();
        chk(!busy && !done && !intr_taken && !wb_valid, "R1", "reset outputs idle", busy, 0);
        chk(!mem_req, "R1", "no request at reset", mem_req, 0);
    endtask

    task automatic test_full_copy();
        int w0;
        bit ok;
        fill_mem();
        w0 = wr_cnt;
        issue(32'h1000, 32'h0000_0010, 32'h0000_0200, 5);
        chk(busy, "R1", "busy after start", busy, 1);
        wait_end();
        chk(done && !intr_taken && wb_valid, "R5", "done pulse with wb_valid", done, 1);
        chk(wb_len == 0, "R5", "final length", wb_len, 0);
        chk(wb_src == 32'h24 && wb_dst == 32'h214, "R3", "final pointers", wb_dst, 32'h214);
        @(negedge clk);
        chk(!done && !busy, "R5", "done lasts one cycle", done, 0);
        chk(wr_cnt - w0 == 5, "R2", "five word writes", wr_cnt - w0, 5);
        ok = 1;
        for (int i = 0; i < 5; i++) if (mem[128 + i] != pattern(4 + i)) ok = 0;
        chk(ok, "R2", "destination data", mem[128], pattern(4));
        chk(mem[133] == 32'hDEAD_0000 + 133, "R2", "word after block untouched", mem[133], 32'hDEAD_0000 + 133);
    endtask

    task automatic test_zero_len();
        int r0;
        r0 = req_cnt;
        issue(32'h2000, 32'h0, 32'h200, 0);
        wait_end();
        chk(done && !intr_taken, "R4", "zero length done", done, 1);
        chk(req_cnt == r0, "R4", "no memory request", req_cnt - r0, 0);
        @(negedge clk);
    endtask

    task automatic test_zero_len_irq();
        irq_req = 1'b1;
        issue(32'h2004, 32'h0, 32'h200, 0);
        wait_end();
        chk(done && !intr_taken, "R10", "completion wins over irq", intr_taken, 0);
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic test_interrupt_resume();
        int w0, n;
        bit ok;
        logic [31:0] s, d, l;
        fill_mem();
        w0 = wr_cnt;
        issue(32'h3000, 32'h0, 32'h200, 12);
        while (wr_cnt - w0 < 4) @(negedge clk);
        irq_req = 1'b1;
        wait_end();
        n = wr_cnt - w0;
        chk(intr_taken && wb_valid && !done, "R7", "suspend pulse", intr_taken, 1);
        chk(wb_len == 12 - n, "R7", "length reflects progress", wb_len, 12 - n);
        chk(wb_src == 4 * n && wb_dst == 32'h200 + 4 * n, "R7", "pointers reflect progress", wb_dst, 32'h200 + 4 * n);
        chk(epc == 32'h3000, "R8", "epc is copy address", epc, 32'h3000);
        chk(mem[128 + n] == 32'hDEAD_0000 + 128 + n, "R6", "no partial word beyond progress", mem[128 + n], 32'hDEAD_0000 + 128 + n);
        s = wb_src; d = wb_dst; l = wb_len;
        @(negedge clk);
        chk(!intr_taken && !busy, "R7", "suspend lasts one cycle", intr_taken, 0);
        irq_req = 1'b0;
        issue(32'h3000, s, d, l);
        wait_end();
        chk(done && wb_len == 0, "R9", "resumed copy completes", wb_len, 0);
        chk(wr_cnt - w0 == 12, "R9", "total writes equal count", wr_cnt - w0, 12);
        ok = 1;
        for (int i = 0; i < 12; i++) if (mem[128 + i] != pattern(i)) ok = 0;
        chk(ok, "R9", "full block copied", mem[139], pattern(11));
        @(negedge clk);
    endtask

    task automatic test_irq_in_read();
        int w0, wr_at;
        fill_mem();
        w0 = wr_cnt;
        issue(32'h4000, 32'h40, 32'h300, 6);
        while (!(mem_req && !mem_we && wr_cnt - w0 >= 2)) @(negedge clk);
        wr_at = wr_cnt;
        irq_req = 1'b1;
        wait_end();
        chk(intr_taken, "R6", "stops after read", intr_taken, 1);
        chk(wr_cnt == wr_at + 1, "R6", "started word still written", wr_cnt - wr_at, 1);
        chk(wb_len == 6 - (wr_cnt - w0), "R6", "length after in-read irq", wb_len, 6 - (wr_cnt - w0));
        chk(mem[192 + wr_cnt - w0 - 1] == pattern(16 + wr_cnt - w0 - 1), "R6", "last word data", mem[192 + wr_cnt - w0 - 1], pattern(16 + wr_cnt - w0 - 1));
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic test_irq_at_start();
        int r0;
        irq_req = 1'b1;
        r0 = req_cnt;
        issue(32'h5000, 32'h20, 32'h280, 3);
        wait_end();
        chk(intr_taken && wb_len == 3 && wb_src == 32'h20 && wb_dst == 32'h280, "R7", "immediate suspend keeps operands", wb_len, 3);
        chk(req_cnt == r0, "R6", "no access before suspend", req_cnt - r0, 0);
        chk(epc == 32'h5000, "R8", "epc on immediate suspend", epc, 32'h5000);
        @(negedge clk);
        irq_req = 1'b0;
    endtask

    task automatic test_start_while_busy();
        int w0;
        fill_mem();
        w0 = wr_cnt;
        issue(32'h6000, 32'h0, 32'h200, 4);
        @(negedge clk);
        @(negedge clk);
        pc_in = 32'h7777; src_in = 32'h100; dst_in = 32'h3F0; len_in = 9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        chk(done && wb_dst == 32'h210 && wb_src == 32'h10, "R11", "second start ignored", wb_dst, 32'h210);
        chk(wr_cnt - w0 == 4, "R11", "write count unchanged", wr_cnt - w0, 4);
        @(negedge clk);
    endtask

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_full_copy();
        test_zero_len();
        test_zero_len_irq();
        test_interrupt_resume();
        test_irq_in_read();
        test_irq_at_start();
        test_start_while_busy();
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule